// File: doc/BRIEF.md
# USB Device Interrupt Status Controller

This block gathers the interrupt causes of a full-speed USB device controller into one status word and one interrupt line. Six bus events arrive as single-cycle pulses from the bus-state logic: suspend, start of frame, end of reset, wakeup, end of resume and upstream resume sent. Each pulse latches a sticky bit. Up to seven endpoint request levels are shown directly, and these bits follow their sources without latching. A mask register selects which bits may raise the combined interrupt output.

Software reads the status word through a small synchronous register bus. It acknowledges event bits by writing ones to a separate clear register. On every start of frame the block also captures the 11-bit frame number. The wakeup bit has special handling. Its capture path stays active while the clock-freeze input is high. It ignores bus activity while the device itself is sending upstream resume. It is dropped automatically when suspend becomes set.

Top module: `usb_dev_irq_status`

## Requirements
- R1: After reset the status word, the enable word, the frame number, the read data and the interrupt output are all zero.
- R2: Event bits sit in the status word (byte offset 0x4) at these positions: suspend bit 0, start of frame bit 1, end of reset bit 2, wakeup bit 3, end of resume bit 4, upstream resume bit 5. A one-cycle pulse sets its bit at the next clock edge. The bit stays set until it is cleared.
- R3: Writing to the clear register (offset 0x8) clears each event bit whose data bit is one. Zero data bits, and any data bit at an endpoint position, change nothing.
- R4: If an event pulse and a clear write for the same bit occur in the same cycle, the bit ends up set.
- R5: Status bits 12 to 18 show endpoint requests 0 to 6 as levels. They follow the request lines and have no latching or clear.
- R6: The enable register (offset 0xC) is read-write and has bits only at the status positions. It reads back the written value masked to bits 5:0 and 18:12. The interrupt output is high exactly when some status bit and its enable bit are both one.
- R7: A start-of-frame pulse loads the frame-number input into the frame-number output at the same edge that sets bit 1.
- R8: When suspend goes from zero to one, wakeup is cleared. If a wakeup pulse arrives in that same cycle, wakeup stays set. A suspend pulse while suspend is already set leaves wakeup unchanged.
- R9: A wakeup pulse is ignored while the upstream-resume-active input is high.
- R10: While freeze is high, every register write and every event pulse other than wakeup is ignored. Wakeup pulses are still captured.
- R11: A write to the status offset changes neither status nor enable.
- R12: Read data is registered. It shows the register selected by the address on the previous edge. Offsets other than 0x4 and 0xC, including the clear register, read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| freezeClk | input | 1 | Clock-freeze control; only wakeup capture stays live |
| evSuspend | input | 1 | Suspend detected pulse |
| evSof | input | 1 | Start-of-frame token pulse |
| sofFrame | input | 11 | Frame number carried by the token |
| evEndReset | input | 1 | End of bus reset pulse |
| evWakeup | input | 1 | Filtered non-idle line activity pulse |
| txResume | input | 1 | High while the device drives upstream resume |
| evEndResume | input | 1 | End of host resume pulse |
| evUpResume | input | 1 | Upstream resume sent pulse |
| epReq | input | 7 | Endpoint request levels |
| busAddr | input | 4 | Register byte address |
| busWrite | input | 1 | Write strobe |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| frameNum | output | 11 | Last captured frame number |
| irqOut | output | 1 | Combined interrupt |

## Verification
The assertions assume that the event inputs are clean single-cycle pulses that are sampled on the rising edge. They also assume that freeze and the upstream-resume-active input are levels that stay stable across an edge. The bench drives every input on the falling edge. It raises each pulse for exactly one cycle and changes freeze only between operations, so every property sees well-formed, edge-aligned stimulus. Concurrent corner cases are created on purpose, with set and clear in the same cycle and suspend and wakeup in the same cycle. They are still applied only at those same falling edges.

// File: rtl/usbirq_pkg.sv
package usbirq_pkg;
  parameter int NUM_EP  = 7;
  parameter int NUM_EV  = 6;
  parameter int FNUM_W  = 11;
  parameter int DATA_W  = 32;
  parameter int ADDR_W  = 4;
  parameter int EP_BASE = 12;

  localparam int EV_SUSP  = 0;
  localparam int EV_SOF   = 1;
  localparam int EV_EORST = 2;
  localparam int EV_WAKE  = 3;
  localparam int EV_EORSM = 4;
  localparam int EV_UPRSM = 5;

  localparam logic [ADDR_W-1:0] ADDR_STATUS = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] ADDR_CLEAR  = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] ADDR_ENABLE = ADDR_W'(12);

  typedef struct packed {
    logic [NUM_EV-1:0] setEv;
    logic [NUM_EV-1:0] clrEv;
    logic              wrEnable;
  } strobes_t;
endpackage

// File: rtl/usbirq_ctrl.sv
module usbirq_ctrl
  import usbirq_pkg::*;
(
  input  logic              freezeClk,
  input  logic              evSuspend,
  input  logic              evSof,
  input  logic              evEndReset,
  input  logic              evWakeup,
  input  logic              txResume,
  input  logic              evEndResume,
  input  logic              evUpResume,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic [DATA_W-1:0] busWdata,
  output strobes_t          strobes
);
  logic liveClk;
  logic [NUM_EV-1:0] rawEv;
  logic [NUM_EV-1:0] gateMask;

  assign liveClk = !freezeClk;

  always_comb begin
    rawEv = '0;
    rawEv[EV_SUSP]  = evSuspend;
    rawEv[EV_SOF]   = evSof;
    rawEv[EV_EORST] = evEndReset;
    rawEv[EV_WAKE]  = evWakeup && !txResume;
    rawEv[EV_EORSM] = evEndResume;
    rawEv[EV_UPRSM] = evUpResume;
  end

  // wakeup capture stays live under freeze, every other source is gated
  for (genvar i = 0; i < NUM_EV; i++) begin : g_gate
    if (i == EV_WAKE) begin : g_live
      assign gateMask[i] = 1'b1;
    end else begin : g_frozen
      assign gateMask[i] = liveClk;
    end
  end

  always_comb begin
    strobes.setEv    = rawEv & gateMask;
    strobes.clrEv    = (busWrite && liveClk && busAddr == ADDR_CLEAR)
                       ? busWdata[NUM_EV-1:0] : '0;
    strobes.wrEnable = busWrite && liveClk && busAddr == ADDR_ENABLE;
  end
endmodule

// File: rtl/usbirq_datapath.sv
module usbirq_datapath
  import usbirq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strobes,
  input  logic [FNUM_W-1:0] sofFrame,
  input  logic [NUM_EP-1:0] epReq,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [NUM_EV-1:0] evStatus,
  output logic [DATA_W-1:0] enableWord,
  output logic [FNUM_W-1:0] frameNum,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqOut
);
  logic [NUM_EV-1:0] evQ, evNext, autoClr;
  logic [NUM_EV-1:0] enEvQ;
  logic [NUM_EP-1:0] enEpQ;
  logic [FNUM_W-1:0] frameQ;
  logic [DATA_W-1:0] statusWord, rdNext, rdQ;
  logic suspRise;

  assign suspRise = strobes.setEv[EV_SUSP] && !evQ[EV_SUSP];

  for (genvar i = 0; i < NUM_EV; i++) begin : g_evbit
    if (i == EV_WAKE) begin : g_wake
      assign autoClr[i] = suspRise;
    end else begin : g_plain
      assign autoClr[i] = 1'b0;
    end
    // a set in the same cycle beats any clear
    assign evNext[i] = strobes.setEv[i] | (evQ[i] & ~strobes.clrEv[i] & ~autoClr[i]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      evQ    <= '0;
      enEvQ  <= '0;
      enEpQ  <= '0;
      frameQ <= '0;
      rdQ    <= '0;
    end else begin
      evQ <= evNext;
      if (strobes.wrEnable) begin
        enEvQ <= busWdata[NUM_EV-1:0];
        enEpQ <= busWdata[EP_BASE +: NUM_EP];
      end
      if (strobes.setEv[EV_SOF]) frameQ <= sofFrame;
      rdQ <= rdNext;
    end
  end

  always_comb begin
    statusWord = '0;
    statusWord[NUM_EV-1:0] = evQ;
    statusWord[EP_BASE +: NUM_EP] = epReq;
    enableWord = '0;
    enableWord[NUM_EV-1:0] = enEvQ;
    enableWord[EP_BASE +: NUM_EP] = enEpQ;
  end

  always_comb begin
    case (busAddr)
      ADDR_STATUS: rdNext = statusWord;
      ADDR_ENABLE: rdNext = enableWord;
      default:     rdNext = '0;
    endcase
  end

  assign irqOut   = |(statusWord & enableWord);
  assign evStatus = evQ;
  assign frameNum = frameQ;
  assign busRdata = rdQ;
endmodule

// File: rtl/usb_dev_irq_status.sv
module usb_dev_irq_status
  import usbirq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              freezeClk,
  input  logic              evSuspend,
  input  logic              evSof,
  input  logic [FNUM_W-1:0] sofFrame,
  input  logic              evEndReset,
  input  logic              evWakeup,
  input  logic              txResume,
  input  logic              evEndResume,
  input  logic              evUpResume,
  input  logic [NUM_EP-1:0] epReq,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic [FNUM_W-1:0] frameNum,
  output logic              irqOut
);
  strobes_t          strobes;
  logic [NUM_EV-1:0] evStatus;
  logic [DATA_W-1:0] enableWord;

  usbirq_ctrl ctrl_i (
    .freezeClk(freezeClk), .evSuspend(evSuspend), .evSof(evSof),
    .evEndReset(evEndReset), .evWakeup(evWakeup), .txResume(txResume),
    .evEndResume(evEndResume), .evUpResume(evUpResume),
    .busAddr(busAddr), .busWrite(busWrite), .busWdata(busWdata),
    .strobes(strobes)
  );

  usbirq_datapath dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .sofFrame(sofFrame),
    .epReq(epReq), .busAddr(busAddr), .busWdata(busWdata),
    .evStatus(evStatus), .enableWord(enableWord), .frameNum(frameNum),
    .busRdata(busRdata), .irqOut(irqOut)
  );
endmodule

// File: rtl/usbirq_checker.sv
module usbirq_checker
  import usbirq_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              freezeClk,
  input logic              evSuspend,
  input logic              evSof,
  input logic [FNUM_W-1:0] sofFrame,
  input logic              evEndReset,
  input logic              evWakeup,
  input logic              txResume,
  input logic [FNUM_W-1:0] frameNum,
  input logic              irqOut,
  input logic [NUM_EV-1:0] evStatus,
  input logic [DATA_W-1:0] enableWord
);
  // R7: frame number taken with every live start of frame
  assert_sof_frame_R7: assert property (@(posedge clk) disable iff (!rstN)
    (evSof && !freezeClk) |=> frameNum == $past(sofFrame));

  // R4: an event pulse always leaves its bit set
  assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rstN)
    (evEndReset && !freezeClk) |=> evStatus[EV_EORST]);

  // R8: suspend rising without a concurrent wakeup drops wakeup
  assert_wake_drop_R8: assert property (@(posedge clk) disable iff (!rstN)
    (evSuspend && !freezeClk && !evStatus[EV_SUSP] && !(evWakeup && !txResume))
    |=> !evStatus[EV_WAKE]);

  // R9: wakeup blocked while sending upstream resume
  assert_tx_block_R9: assert property (@(posedge clk) disable iff (!rstN)
    (evWakeup && txResume && !evStatus[EV_WAKE]) |=> !evStatus[EV_WAKE]);

  // R10: under freeze all non-wakeup bits hold
  assert_freeze_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    freezeClk |=> $stable({evStatus[5:4], evStatus[2:0]}));

  // R6: nothing enabled means no interrupt
  assert_irq_mask_R6: assert property (@(posedge clk) disable iff (!rstN)
    (enableWord == '0) |-> !irqOut);
endmodule

bind usb_dev_irq_status usbirq_checker chk_i (
  .clk(clk), .rstN(rstN), .freezeClk(freezeClk), .evSuspend(evSuspend),
  .evSof(evSof), .sofFrame(sofFrame), .evEndReset(evEndReset),
  .evWakeup(evWakeup), .txResume(txResume), .frameNum(frameNum),
  .irqOut(irqOut), .evStatus(evStatus), .enableWord(enableWord)
);

// File: tb/usb_dev_irq_status_tb_top.sv
`timescale 1ns/1ps
module usb_dev_irq_status_tb_top;
  logic        clk = 0;
  logic        rstN = 0;
  logic        freezeClk = 0;
  logic [5:0]  ev = '0;
  logic        txResume = 0;
  logic [10:0] sofFrame = '0;
  logic [6:0]  epReq = '0;
  logic [3:0]  busAddr = '0;
  logic        busWrite = 0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [10:0] frameNum;
  logic        irqOut;
  int total = 0, bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  usb_dev_irq_status dut_i (
    .clk(clk), .rstN(rstN), .freezeClk(freezeClk),
    .evSuspend(ev[0]), .evSof(ev[1]), .sofFrame(sofFrame),
    .evEndReset(ev[2]), .evWakeup(ev[3]), .txResume(txResume),
    .evEndResume(ev[4]), .evUpResume(ev[5]), .epReq(epReq),
    .busAddr(busAddr), .busWrite(busWrite), .busWdata(busWdata),
    .busRdata(busRdata), .frameNum(frameNum), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    busAddr = a; busWrite = 0;
    @(negedge clk);
    d = busRdata;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    busAddr = a; busWdata = d; busWrite = 1;
    @(negedge clk);
    busWrite = 0;
  endtask

  task automatic pulse(input logic [5:0] m);
    ev = m;
    @(negedge clk);
    ev = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    rd(4'h4, d);  check("R1 status", d, 0);
    rd(4'h0, d);  check("R1 rdata", d, 0);
    rd(4'hC, d);  check("R1 enable", d, 0);
    check("R1 frame", 32'(frameNum), 0);
    check("R1 irq", 32'(irqOut), 0);

    // R2 R3 R6 R7 per-event sweep
    for (int i = 0; i < 6; i++) begin
      wr(4'h8, 32'h3F);
      sofFrame = 11'(i * 300 + 7);
      pulse(6'(1 << i));
      rd(4'h4, d);  check("R2 set", d, 32'(1 << i));
      if (i == 1) check("R7 frame", 32'(frameNum), 32'(i * 300 + 7));
      wr(4'hC, 32'(1 << i));
      check("R6 irq on", 32'(irqOut), 1);
      wr(4'hC, 32'(~(1 << i)) & 32'h7F03F);
      check("R6 irq off", 32'(irqOut), 0);
      wr(4'hC, 0);
      wr(4'h8, 32'(~(1 << i)));
      rd(4'h4, d);  check("R3 other clears", d, 32'(1 << i));
      wr(4'h8, 32'(1 << i));
      rd(4'h4, d);  check("R3 cleared", d, 0);
    end

    // R4 set beats clear
    for (int i = 0; i < 6; i++) begin
      busAddr = 4'h8; busWdata = 32'(1 << i); busWrite = 1; ev = 6'(1 << i);
      @(negedge clk);
      busWrite = 0; ev = '0;
      rd(4'h4, d);  check("R4 set wins", d, 32'(1 << i));
      wr(4'h8, 32'h3F);
    end

    // R6 enable readback
    wr(4'hC, 32'hFFFF_FFFF);
    rd(4'hC, d);  check("R6 enable mask", d, 32'h7F03F);
    wr(4'hC, 0);

    // R5 endpoint level sweep with irq masking
    for (int v = 0; v < 128; v++) begin
      logic [6:0] m;
      m = 7'((v * 5 + 3) & 127);
      epReq = 7'(v);
      wr(4'hC, 32'(m) << 12);
      wr(4'h8, 32'h7F000);
      rd(4'h4, d);  check("R5 ep level", d, 32'(v) << 12);
      check("R6 ep irq", 32'(irqOut), 32'((7'(v) & m) != 0));
    end
    epReq = '0;
    rd(4'h4, d);  check("R5 ep follows", d, 0);
    wr(4'hC, 0);

    // R8 wakeup and suspend interplay
    wr(4'h8, 32'h3F);
    pulse(6'h08);
    pulse(6'h01);
    rd(4'h4, d);  check("R8 suspend drops wake", d, 32'h01);
    pulse(6'h08);
    pulse(6'h01);
    rd(4'h4, d);  check("R8 suspend already set", d, 32'h09);
    wr(4'h8, 32'h3F);
    pulse(6'h09);
    rd(4'h4, d);  check("R8 same cycle wake", d, 32'h09);
    wr(4'h8, 32'h3F);

    // R9 blocked by upstream resume activity
    txResume = 1;
    pulse(6'h08);
    txResume = 0;
    rd(4'h4, d);  check("R9 wake blocked", d, 0);

    // R10 freeze
    freezeClk = 1;
    sofFrame = 11'h555;
    pulse(6'h37);
    rd(4'h4, d);  check("R10 frozen events", d, 0);
    check("R10 frozen frame", 32'(frameNum), 32'(5 * 300 + 7) & 32'h7FF);
    pulse(6'h08);
    rd(4'h4, d);  check("R10 wake live", d, 32'h08);
    wr(4'h8, 32'h08);
    wr(4'hC, 32'h08);
    rd(4'h4, d);  check("R10 clear ignored", d, 32'h08);
    rd(4'hC, d);  check("R10 enable ignored", d, 0);
    freezeClk = 0;
    wr(4'h8, 32'h08);
    rd(4'h4, d);  check("R10 unfrozen clear", d, 0);

    // R11 status write ignored
    wr(4'hC, 32'h04);
    pulse(6'h02);
    wr(4'h4, 32'hFFFF_FFFF);
    rd(4'h4, d);  check("R11 status kept", d, 32'h02);
    rd(4'hC, d);  check("R11 enable kept", d, 32'h04);

    // R12 registered read and unmapped offsets
    rd(4'h0, d);  check("R12 addr0", d, 0);
    rd(4'h8, d);  check("R12 clear reads zero", d, 0);
    rd(4'h2, d);  check("R12 addr2", d, 0);
    busAddr = 4'h4;
    #1;
    check("R12 before edge", busRdata, 0);
    @(negedge clk);
    check("R12 after edge", busRdata, 32'h02);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule